// File: doc/BRIEF.md
# Split-Clock Decade Counter

This block is a 4-bit counter made of two sections that count independently. The low section is a toggle stage driven by count input A and produces bit 0 of the output. The high section is a modulo-5 stage driven by count input B and produces bits 3 to 1. Each section advances when its own count input goes from high to low. A build-time mode parameter decides how the two sections are joined: no link (two separate dividers), a BCD link where the wrap of bit 0 steps the high section, or a bi-quinary link where the wrap of the high section steps bit 0. The bi-quinary link gives a square wave with a 50% duty cycle on bit 0 at one tenth of the count rate on B.

The count inputs are treated as slow data. They pass through a synchronizer onto the system clock, and their falling edges become one-cycle step enables. The link between the sections is therefore a multiplexer on step enables, not a rippled clock. Two control pairs act at once on the output, with no wait for a clock. Clear forces zero when both of its inputs are high. Preset forces nine when both of its inputs are high, and preset wins over clear. While a pair is active, the registers are loaded with the forced value on every clock edge, so counting resumes from that value once the pair is released.

Top module: `decade_ripple_counter`

## Requirements
- R1: After rst_n is asserted low and released, q_o reads 4'b0000 while no clear or preset pair is active.
- R2: A section steps only on a high-to-low transition of its count input. A rising transition changes nothing. The output reflects a step within 3 clk cycles after the falling transition.
- R3: When clr_a_i and clr_b_i are both high and the preset pair is not, q_o reads 0000 without waiting for a clock edge, and count transitions are ignored. One clear input alone has no effect.
- R4: When set_a_i and set_b_i are both high, q_o reads 1001 without waiting for a clock edge, whatever the clear pair does. One preset input alone has no effect.
- R5: The high section field q_o[3:1] steps 000, 001, 010, 011, 100 and then back to 000, so q_o[3] is high for one step in five.
- R6: With MODE = LINK_SPLIT, each falling transition of cnt_a_i toggles q_o[0] and each falling transition of cnt_b_i steps q_o[3:1], each with no effect on the other section.
- R7: With MODE = LINK_BCD, falling transitions of cnt_a_i count q_o (bit weights 8,4,2,1 on bits 3..0) through 0 to 9 and then back to 0.
- R8: With MODE = LINK_BCD, transitions of cnt_b_i have no effect on q_o.
- R9: With MODE = LINK_BIQUINARY, falling transitions of cnt_b_i step q_o[3:1], and q_o[0] toggles exactly when q_o[3:1] wraps from 100 to 000. This gives the sequence 0,2,4,6,8,1,3,5,7,9 and keeps q_o[0] high for 5 of every 10 steps.
- R10: With MODE = LINK_BIQUINARY, transitions of cnt_a_i have no effect on q_o.
- R11: After a preset is released, counting resumes from 1001. In the BCD and bi-quinary links, the next step gives 0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset: asserts at once, releases on the clock |
| cnt_a_i | input | 1 | Count input of the toggle section (bit 0) |
| cnt_b_i | input | 1 | Count input of the modulo-5 section (bits 3..1) |
| clr_a_i | input | 1 | Clear qualifier, first of a pair |
| clr_b_i | input | 1 | Clear qualifier, second of a pair |
| set_a_i | input | 1 | Preset-to-nine qualifier, first of a pair |
| set_b_i | input | 1 | Preset-to-nine qualifier, second of a pair |
| q_o | output | 4 | Count value, bit 3 most significant |

## Verification
The checks run on every cycle cover the following: the forced values of the clear and preset pairs and their priority, the legal range of the modulo-5 field, the +1 modulo-10 step of the BCD link, and the rule in the bi-quinary link that bit 0 moves only on a wrap of the high field. Some behaviour shows only in the bench scenarios, which count pulses against a behavioural model for all three links. This covers the rejection of rising transitions, the immunity of each linked mode to its unused count input, the effect of a single input of a pair (none), a count pulse swallowed during clear, the 5-of-10 duty of bi-quinary bit 0, and the resume from nine after a preset.

// File: rtl/dcr_pkg.sv
package dcr_pkg;
  typedef enum logic [1:0] {
    LINK_BCD       = 2'd0,
    LINK_BIQUINARY = 2'd1,
    LINK_SPLIT     = 2'd2
  } link_mode_e;

  localparam int HI_W = 3;
  localparam int Q_W  = HI_W + 1;
  localparam logic [HI_W-1:0] HI_LAST   = 3'b100;
  localparam logic [Q_W-1:0]  PRESET_VAL = 4'b1001;
endpackage

// File: rtl/dcr_rst_sync.sv
module dcr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] pipe_q;
  logic [STAGES-1:0] pipe_d;

  for (genvar g = 0; g < STAGES; g++) begin : g_pipe
    if (g == 0) begin : g_first
      assign pipe_d[g] = 1'b1;
    end else begin : g_rest
      assign pipe_d[g] = pipe_q[g-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= pipe_d;
  end

  assign rst_sync_n = pipe_q[STAGES-1];
endmodule

// File: rtl/dcr_fall_detect.sv
module dcr_fall_detect #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              last_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      assign sync_d[g] = din;
    end else begin : g_rest
      assign sync_d[g] = sync_q[g-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      last_q <= sync_q[STAGES-1];
    end
  end

  assign fall_o = last_q & ~sync_q[STAGES-1];
endmodule

// File: rtl/dcr_force_ctl.sv
module dcr_force_ctl (
  input  logic clr_a_i,
  input  logic clr_b_i,
  input  logic set_a_i,
  input  logic set_b_i,
  output logic force_set_o,
  output logic force_clr_o
);
  always_comb begin
    force_set_o = set_a_i & set_b_i;
    force_clr_o = clr_a_i & clr_b_i & ~force_set_o;
  end
endmodule

// File: rtl/dcr_div2_stage.sv
module dcr_div2_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic force_set,
  input  logic force_clr,
  input  logic step_en,
  output logic q
);
  logic q_q;
  logic q_d;
  logic load_en;

  always_comb begin
    load_en = force_set | force_clr | step_en;
    if (force_set)      q_d = 1'b1;
    else if (force_clr) q_d = 1'b0;
    else                q_d = ~q_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q_q <= 1'b0;
    else if (load_en) q_q <= q_d;
  end

  assign q = q_q;
endmodule

// File: rtl/dcr_div5_stage.sv
module dcr_div5_stage
  import dcr_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            force_set,
  input  logic            force_clr,
  input  logic            step_en,
  output logic [HI_W-1:0] q
);
  logic [HI_W-1:0] st_q;
  logic [HI_W-1:0] st_d;
  logic [HI_W-1:0] st_inc;
  logic            load_en;

  always_comb begin
    unique case (st_q)
      3'b000:  st_inc = 3'b001;
      3'b001:  st_inc = 3'b010;
      3'b010:  st_inc = 3'b011;
      3'b011:  st_inc = HI_LAST;
      default: st_inc = 3'b000;
    endcase
  end

  always_comb begin
    load_en = force_set | force_clr | step_en;
    if (force_set)      st_d = PRESET_VAL[Q_W-1:1];
    else if (force_clr) st_d = '0;
    else                st_d = st_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       st_q <= '0;
    else if (load_en) st_q <= st_d;
  end

  assign q = st_q;
endmodule

// File: rtl/decade_ripple_counter.sv
module decade_ripple_counter
  import dcr_pkg::*;
#(
  parameter link_mode_e MODE        = LINK_BCD,
  parameter int         SYNC_STAGES = 2,
  parameter int         RST_STAGES  = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cnt_a_i,
  input  logic           cnt_b_i,
  input  logic           clr_a_i,
  input  logic           clr_b_i,
  input  logic           set_a_i,
  input  logic           set_b_i,
  output logic [Q_W-1:0] q_o
);
  logic            rst_int_n;
  logic            fall_a;
  logic            fall_b;
  logic            force_set;
  logic            force_clr;
  logic            step_lo;
  logic            step_hi;
  logic            lo_q;
  logic [HI_W-1:0] hi_q;
  logic            lo_wrap;
  logic            hi_wrap;

  dcr_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  dcr_fall_detect #(.STAGES(SYNC_STAGES)) u_fall_a (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .din    (cnt_a_i),
    .fall_o (fall_a)
  );

  dcr_fall_detect #(.STAGES(SYNC_STAGES)) u_fall_b (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .din    (cnt_b_i),
    .fall_o (fall_b)
  );

  dcr_force_ctl u_force (
    .clr_a_i     (clr_a_i),
    .clr_b_i     (clr_b_i),
    .set_a_i     (set_a_i),
    .set_b_i     (set_b_i),
    .force_set_o (force_set),
    .force_clr_o (force_clr)
  );

  // A section "wraps" when its own step takes its output bit from high to low.
  always_comb begin
    lo_wrap = lo_q;
    hi_wrap = (hi_q == HI_LAST);
  end

  // Link multiplexer: the parameter picks which step enable drives each section.
  always_comb begin
    unique case (MODE)
      LINK_BCD: begin
        step_lo = fall_a;
        step_hi = fall_a & lo_wrap;
      end
      LINK_BIQUINARY: begin
        step_hi = fall_b;
        step_lo = fall_b & hi_wrap;
      end
      default: begin
        step_lo = fall_a;
        step_hi = fall_b;
      end
    endcase
  end

  dcr_div2_stage u_lo (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .force_set (force_set),
    .force_clr (force_clr),
    .step_en   (step_lo),
    .q         (lo_q)
  );

  dcr_div5_stage u_hi (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .force_set (force_set),
    .force_clr (force_clr),
    .step_en   (step_hi),
    .q         (hi_q)
  );

  // Forced values reach the output at once, ahead of the registers.
  always_comb begin
    if (force_set)      q_o = PRESET_VAL;
    else if (force_clr) q_o = '0;
    else                q_o = {hi_q, lo_q};
  end
endmodule

// File: rtl/decade_ripple_counter_chk.sv
module decade_ripple_counter_chk
  import dcr_pkg::*;
#(
  parameter link_mode_e MODE = LINK_BCD
) (
  input logic           clk,
  input logic           rst_n,
  input logic           clr_a_i,
  input logic           clr_b_i,
  input logic           set_a_i,
  input logic           set_b_i,
  input logic [Q_W-1:0] q_o
);
  logic clr_pair;
  logic set_pair;
  logic forced;
  logic is_bcd;
  logic is_biq;

  always_comb begin
    clr_pair = clr_a_i & clr_b_i;
    set_pair = set_a_i & set_b_i;
    forced   = clr_pair | set_pair;
    is_bcd   = (MODE == LINK_BCD);
    is_biq   = (MODE == LINK_BIQUINARY);
  end

  p_clear_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_pair && !set_pair) |-> (q_o == 4'b0000));

  p_preset_nine_r4: assert property (@(posedge clk) disable iff (!rst_n)
    set_pair |-> (q_o == 4'b1001));

  p_hi_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (q_o[3:1] <= 3'd4));

  p_bcd_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    is_bcd |-> (q_o <= 4'd9));

  p_bcd_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (is_bcd && !forced && !$past(forced) && (q_o != $past(q_o)))
      |-> (q_o == (($past(q_o) == 4'd9) ? 4'd0 : $past(q_o) + 4'd1)));

  p_biq_toggle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (is_biq && !forced && !$past(forced) && (q_o[0] != $past(q_o[0])))
      |-> (($past(q_o[3:1]) == 3'b100) && (q_o[3:1] == 3'b000)));
endmodule

bind decade_ripple_counter decade_ripple_counter_chk #(.MODE(MODE)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .clr_a_i (clr_a_i),
  .clr_b_i (clr_b_i),
  .set_a_i (set_a_i),
  .set_b_i (set_b_i),
  .q_o     (q_o)
);

// File: tb/decade_ripple_counter_tb.sv
module decade_ripple_counter_tb;
  import dcr_pkg::*;

  logic clk;
  logic rst_n;
  logic cnt_a, cnt_b, clr_a, clr_b, set_a, set_b;
  logic [3:0] q_bcd, q_biq, q_spl;

  int checks;
  int errors;
  int cycles;
  bit done;

  // behavioural reference state
  int bcd_n;
  int biq_n;
  int spl_a;
  int spl_b;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  decade_ripple_counter #(.MODE(LINK_BCD)) u_dut (
    .clk(clk), .rst_n(rst_n), .cnt_a_i(cnt_a), .cnt_b_i(cnt_b),
    .clr_a_i(clr_a), .clr_b_i(clr_b), .set_a_i(set_a), .set_b_i(set_b),
    .q_o(q_bcd));

  decade_ripple_counter #(.MODE(LINK_BIQUINARY)) u_dut_bq (
    .clk(clk), .rst_n(rst_n), .cnt_a_i(cnt_a), .cnt_b_i(cnt_b),
    .clr_a_i(clr_a), .clr_b_i(clr_b), .set_a_i(set_a), .set_b_i(set_b),
    .q_o(q_biq));

  decade_ripple_counter #(.MODE(LINK_SPLIT)) u_dut_sp (
    .clk(clk), .rst_n(rst_n), .cnt_a_i(cnt_a), .cnt_b_i(cnt_b),
    .clr_a_i(clr_a), .clr_b_i(clr_b), .set_a_i(set_a), .set_b_i(set_b),
    .q_o(q_spl));

  function automatic logic [3:0] exp_bcd();
    return 4'(bcd_n);
  endfunction
  function automatic logic [3:0] exp_biq();
    return 4'((biq_n % 5) * 2 + ((biq_n >= 5) ? 1 : 0));
  endfunction
  function automatic logic [3:0] exp_spl();
    return 4'(spl_b * 2 + spl_a);
  endfunction

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic chk_all(input string tag);
    chk({tag, " bcd"}, q_bcd, exp_bcd());
    chk({tag, " biq"}, q_biq, exp_biq());
    chk({tag, " split"}, q_spl, exp_spl());
  endtask

  task automatic wait_neg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_a();
    cnt_a = 1'b1;
    wait_neg(6);
    cnt_a = 1'b0;
    wait_neg(6);
    bcd_n = (bcd_n + 1) % 10;
    spl_a = (spl_a + 1) % 2;
  endtask

  task automatic pulse_b();
    cnt_b = 1'b1;
    wait_neg(6);
    cnt_b = 1'b0;
    wait_neg(6);
    biq_n = (biq_n + 1) % 10;
    spl_b = (spl_b + 1) % 5;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<=100000 cycles", cycles);
      finish_run();
    end
  end

  initial begin
    int high_cnt;
    checks = 0; errors = 0; cycles = 0; done = 1'b0;
    bcd_n = 0; biq_n = 0; spl_a = 0; spl_b = 0;
    rst_n = 1'b0;
    cnt_a = 0; cnt_b = 0; clr_a = 0; clr_b = 0; set_a = 0; set_b = 0;
    wait_neg(5);
    rst_n = 1'b1;
    wait_neg(4);
    chk_all("R1 reset");

    // R2: rising transition alone changes nothing; update within 3 cycles of fall
    cnt_a = 1'b1;
    wait_neg(6);
    chk("R2 rise ignored bcd", q_bcd, 4'd0);
    chk("R2 rise ignored split", q_spl, 4'd0);
    cnt_a = 1'b0;
    wait_neg(3);
    bcd_n = 1; spl_a = 1;
    chk("R2 fall latency bcd", q_bcd, exp_bcd());
    chk("R2 fall latency split", q_spl, exp_spl());
    wait_neg(3);

    // R7 BCD sequence with wrap; R6 split toggle; R10 biq ignores A
    for (int i = 0; i < 11; i++) begin
      pulse_a();
      chk("R7 bcd count", q_bcd, exp_bcd());
      chk("R6 split lo toggle", q_spl, exp_spl());
      chk("R10 biq ignores cnt_a", q_biq, exp_biq());
    end

    // R9 bi-quinary sequence; R8 BCD ignores B; R5 split hi field
    high_cnt = 0;
    for (int i = 0; i < 10; i++) begin
      pulse_b();
      chk("R9 biq sequence", q_biq, exp_biq());
      chk("R8 bcd ignores cnt_b", q_bcd, exp_bcd());
      chk("R5 split hi step", q_spl, exp_spl());
      if (q_biq[0]) high_cnt++;
    end
    chk("R9 biq duty 5 of 10", 4'(high_cnt), 4'd5);
    pulse_b();
    pulse_b();
    chk_all("R5 R9 after extra steps");

    // R3 clear: one input alone has no effect
    clr_a = 1'b1;
    wait_neg(3);
    chk_all("R3 single clear input");
    clr_b = 1'b1;
    #1;
    bcd_n = 0; biq_n = 0; spl_a = 0; spl_b = 0;
    chk_all("R3 clear immediate");
    cnt_a = 1'b1; cnt_b = 1'b1;
    wait_neg(6);
    cnt_a = 1'b0; cnt_b = 1'b0;
    wait_neg(6);
    chk_all("R3 counts ignored in clear");
    clr_a = 1'b0; clr_b = 1'b0;
    wait_neg(4);
    chk_all("R3 after clear release");

    // R4 preset: single input no effect, then priority over clear
    pulse_a();
    pulse_b();
    set_b = 1'b1;
    wait_neg(3);
    chk_all("R4 single preset input");
    clr_a = 1'b1; clr_b = 1'b1; set_a = 1'b1;
    #1;
    bcd_n = 9; biq_n = 9; spl_a = 1; spl_b = 4;
    chk_all("R4 preset over clear");
    wait_neg(3);
    clr_a = 0; clr_b = 0; set_a = 0; set_b = 0;
    wait_neg(4);
    chk_all("R4 held after release");

    // R11 resume from nine
    pulse_a();
    chk("R11 bcd nine to zero", q_bcd, 4'd0);
    chk("R11 split lo from preset", q_spl, exp_spl());
    pulse_b();
    chk("R11 biq nine to zero", q_biq, 4'd0);
    chk("R11 split hi from preset", q_spl, exp_spl());
    chk_all("R11 final");

    finish_run();
  end
endmodule